// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block runs the power-up sequence of a card that can be plugged in and pulled out of a live backplane. The analog side of the card compares its supplies and its sense resistor against thresholds and hands the results over as digital flags. The block reads those flags together with two active-low board-select inputs, a host power-enable, a strap that picks which host supply counts, a host reset input and a breaker-trip flag. It drives the enables for the two supply gate drivers, an active-low driver-enable status, active-low health and signal-valid status outputs, and a pair of local reset outputs, one active-low and one active-high.

The gates turn on only when the card is fully seated, the host allows power and the chosen host supply is good. Once the card-side supplies are up, a reset-hold timer runs. The local resets are released and signal-valid is asserted only after that timer expires. A host reset that survives the glitch filter starts the hold time over, and the hold lasts for as long as the host keeps its reset low. A sag on a card supply pulls the card back into reset but leaves the gates on. A breaker trip latches the gates off until the host cycles power-enable.

Every input is asynchronous and passes through a two-flop synchronizer. Timer lengths are given in clock cycles: `RST_CYC` is the reset hold time (150 ms at the target clock) and `GLITCH_CYC` is the shortest host reset pulse that is accepted.

Top module: `hs_power_seq`

## Requirements
- R1: While `rst` is high and after it falls, until inputs allow otherwise, `gate3_en`=`gate5_en`=0, `drv_en_n`=1, `healthy_n`=1, `sig_valid_n`=1, `lrst_n`=0 and `lrst`=1.
- R2: The gate outputs (`gate3_en`, `gate5_en` high, `drv_en_n` low) become active only when `brd_sel_a_n` and `brd_sel_b_n` are both 0, `pwr_en` is 1, the selected host monitor is 1 and no breaker fault is latched. An input change reaches the gate outputs on the third rising edge after it is sampled.
- R3: With `strap_3v3`=1 only `host3_ok` decides whether the host supply is good. With `strap_3v3`=0 only `host5_ok` decides. The monitor that is not selected has no effect.
- R4: When `card3_ok` or `card5_ok` falls while the gates are on, `healthy_n` goes to 1 and the local resets are asserted. The gates stay on.
- R5: `healthy_n` is 0 exactly when the gates are on and both card monitors are 1.
- R6: `lrst_n` goes to 1 and `sig_valid_n` goes to 0 only after `RST_CYC` consecutive synchronized cycles in which the gates are on, both card monitors are 1 and no host reset is accepted.
- R7: `lrst` is always the complement of `lrst_n`.
- R8: A low pulse on `host_rst_n` lasting fewer than `GLITCH_CYC` synchronized cycles has no effect on any output.
- R9: A low pulse on `host_rst_n` of `GLITCH_CYC` cycles or more asserts the local resets and de-asserts signal-valid. They stay that way while `host_rst_n` is low and for the full `RST_CYC` hold time after it returns high.
- R10: `brk_trip` high while the gates are on latches a fault that turns the gates off. They stay off after the trip clears, until `pwr_en` has been low and then high again.
- R11: Taking `pwr_en` low, or driving either board-select input high, turns the gates off, de-asserts health and asserts the local resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host5_ok | input | 1 | Host 5 V supply at or above threshold |
| host3_ok | input | 1 | Host 3.3 V supply at or above threshold |
| card5_ok | input | 1 | Card 5 V supply at or above threshold |
| card3_ok | input | 1 | Card 3.3 V supply at or above threshold |
| brd_sel_a_n | input | 1 | First board-select, low = seated |
| brd_sel_b_n | input | 1 | Second board-select, low = seated |
| pwr_en | input | 1 | Host power enable |
| strap_3v3 | input | 1 | 1 = judge the host by its 3.3 V monitor, 0 = by its 5 V monitor |
| host_rst_n | input | 1 | Host reset request, active low |
| brk_trip | input | 1 | Over-current breaker trip flag |
| gate3_en | output | 1 | Enable for the 3.3 V gate driver |
| gate5_en | output | 1 | Enable for the 5 V gate driver |
| drv_en_n | output | 1 | Gates-on status, active low |
| healthy_n | output | 1 | Card supplies good, active low |
| sig_valid_n | output | 1 | Card powered and out of reset, active low |
| lrst_n | output | 1 | Local reset, active low |
| lrst | output | 1 | Local reset, active high |

## Verification
The hardest case to reach is a host reset that arrives after the card is fully up and running. The hold timer must already have expired once before the stretch can be seen, and the filter boundary is one synchronized cycle wide. The stimulus brings the card to its running state first. It then sends a one-cycle reset pulse, which must be rejected, and after that a long pulse, with reset release sampled both inside and after the restarted hold window. The latched breaker fault is reached the same way: the trip comes only once the gates are on, and the fault is then cleared by cycling `pwr_en`.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        PS_OFF       = 2'd0,
        PS_WAIT_CARD = 2'd1,
        PS_TIMING    = 2'd2,
        PS_RUN       = 2'd3
    } pstate_e;

    typedef struct packed {
        logic host5_ok;
        logic host3_ok;
        logic card5_ok;
        logic card3_ok;
        logic sel_a_n;
        logic sel_b_n;
        logic pwr_en;
        logic strap_3v3;
        logic hrst_n;
        logic trip;
    } mon_s;

    localparam int MON_W = $bits(mon_s);

    // safe values held by the synchronizers during reset
    localparam mon_s MON_SAFE = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
                                  1'b0, 1'b0, 1'b1, 1'b0};

    function automatic logic host_good(mon_s m);
        return m.strap_3v3 ? m.host3_ok : m.host5_ok;
    endfunction

    function automatic logic card_good(mon_s m);
        return m.card5_ok & m.card3_ok;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int               W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/hs_hrst_filter.sv
module hs_hrst_filter #(
    parameter int GLITCH_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hrst_n_s,
    output logic hreq
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(GLITCH_CYC);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || hrst_n_s) begin
            low_cnt <= '0;
        end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign hreq = (low_cnt == LIMIT);
endmodule

// File: rtl/hs_rst_timer.sv
module hs_rst_timer #(
    parameter int RST_CYC = 7_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic done
);
    localparam int TW = $clog2(RST_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(RST_CYC);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tcnt <= '0;
        end else if (tcnt != LIMIT) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    assign done = (tcnt == LIMIT);
endmodule

// File: rtl/hs_power_seq.sv
module hs_power_seq
    import hs_pkg::*;
#(
    parameter int RST_CYC    = 7_500_000,
    parameter int GLITCH_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic host5_ok,
    input  logic host3_ok,
    input  logic card5_ok,
    input  logic card3_ok,
    input  logic brd_sel_a_n,
    input  logic brd_sel_b_n,
    input  logic pwr_en,
    input  logic strap_3v3,
    input  logic host_rst_n,
    input  logic brk_trip,
    output logic gate3_en,
    output logic gate5_en,
    output logic drv_en_n,
    output logic healthy_n,
    output logic sig_valid_n,
    output logic lrst_n,
    output logic lrst
);
    mon_s        raw;
    mon_s        syn;
    logic [MON_W-1:0] syn_vec;

    assign raw = '{host5_ok, host3_ok, card5_ok, card3_ok, brd_sel_a_n,
                   brd_sel_b_n, pwr_en, strap_3v3, host_rst_n, brk_trip};

    hs_sync #(.W(MON_W), .RST_VAL(MON_SAFE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn_vec)
    );
    assign syn = mon_s'(syn_vec);

    logic hreq;
    hs_hrst_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .hrst_n_s (syn.hrst_n),
        .hreq     (hreq)
    );

    pstate_e state_q, state_d;
    logic    fault_q;
    logic    power_ok, card_ok, tmr_clr, tmr_done;

    assign power_ok = host_good(syn) & ~syn.sel_a_n & ~syn.sel_b_n
                    & syn.pwr_en & ~fault_q;
    assign card_ok  = card_good(syn);
    assign tmr_clr  = ~(power_ok & card_ok) | hreq;

    hs_rst_timer #(.RST_CYC(RST_CYC)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .done (tmr_done)
    );

    always_comb begin
        if (!power_ok)
            state_d = PS_OFF;
        else if (!card_ok)
            state_d = PS_WAIT_CARD;
        else if (hreq || !tmr_done)
            state_d = PS_TIMING;
        else
            state_d = PS_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_OFF;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!syn.pwr_en)
                fault_q <= 1'b0;
            else if (syn.trip && state_q != PS_OFF)
                fault_q <= 1'b1;
        end
    end

    logic gates_on, in_reset;
    assign gates_on    = (state_q != PS_OFF);
    assign in_reset    = (state_q != PS_RUN);

    assign gate3_en    = gates_on;
    assign gate5_en    = gates_on;
    assign drv_en_n    = ~gates_on;
    assign healthy_n   = ~(state_q == PS_TIMING || state_q == PS_RUN);
    assign sig_valid_n = in_reset;
    assign lrst_n      = ~in_reset;
    assign lrst        = in_reset;
endmodule

// File: rtl/hs_power_seq_chk.sv
module hs_power_seq_chk (
    input logic clk,
    input logic rst,
    input logic brd_sel_a_n,
    input logic brd_sel_b_n,
    input logic pwr_en,
    input logic gate3_en,
    input logic gate5_en,
    input logic healthy_n,
    input logic sig_valid_n,
    input logic lrst_n,
    input logic lrst
);
    AST_VALID_HAS_GATES: assert property (@(posedge clk) disable iff (rst)
        !sig_valid_n |-> (gate3_en && gate5_en)); // R6

    AST_VALID_NOT_IN_RST: assert property (@(posedge clk) disable iff (rst)
        !sig_valid_n |-> (lrst_n && !healthy_n)); // R6

    AST_HEALTH_HAS_GATES: assert property (@(posedge clk) disable iff (rst)
        !healthy_n |-> gate3_en); // R5

    AST_RST_PAIR: assert property (@(posedge clk) disable iff (rst)
        lrst != lrst_n); // R7

    AST_SEL_OPEN_OFF: assert property (@(posedge clk) disable iff (rst)
        ($past(brd_sel_a_n, 3) || $past(brd_sel_b_n, 3)) |-> (!gate3_en && !gate5_en)); // R11

    AST_PWR_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
        !$past(pwr_en, 3) |-> !gate3_en); // R11
endmodule

bind hs_power_seq hs_power_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .brd_sel_a_n (brd_sel_a_n),
    .brd_sel_b_n (brd_sel_b_n),
    .pwr_en      (pwr_en),
    .gate3_en    (gate3_en),
    .gate5_en    (gate5_en),
    .healthy_n   (healthy_n),
    .sig_valid_n (sig_valid_n),
    .lrst_n      (lrst_n),
    .lrst        (lrst)
);

// File: tb/tb_hs_power_seq.sv
module tb_hs_power_seq;
    localparam int RSTC = 20;
    localparam int GLT  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host5_ok = 0, host3_ok = 0, card5_ok = 0, card3_ok = 0;
    logic brd_sel_a_n = 1, brd_sel_b_n = 1, pwr_en = 0, strap_3v3 = 0;
    logic host_rst_n = 1, brk_trip = 0;
    logic gate3_en, gate5_en, drv_en_n, healthy_n, sig_valid_n, lrst_n, lrst;

    always #10 clk = ~clk; // 50 MHz

    hs_power_seq #(.RST_CYC(RSTC), .GLITCH_CYC(GLT)) dut (
        .clk(clk), .rst(rst),
        .host5_ok(host5_ok), .host3_ok(host3_ok),
        .card5_ok(card5_ok), .card3_ok(card3_ok),
        .brd_sel_a_n(brd_sel_a_n), .brd_sel_b_n(brd_sel_b_n),
        .pwr_en(pwr_en), .strap_3v3(strap_3v3),
        .host_rst_n(host_rst_n), .brk_trip(brk_trip),
        .gate3_en(gate3_en), .gate5_en(gate5_en), .drv_en_n(drv_en_n),
        .healthy_n(healthy_n), .sig_valid_n(sig_valid_n),
        .lrst_n(lrst_n), .lrst(lrst)
    );

    int errors = 0;
    int checks = 0;

    task automatic expect_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // delayed views of the inputs (two sampling stages)
    bit d1[10], d2[10];
    bit m_fault;
    int m_low;     // consecutive synchronized host-reset-low cycles, capped
    int m_good;    // consecutive qualifying cycles, capped
    int m_mode;    // 0 off, 1 gates on/card bad, 2 holding reset, 3 running

    function automatic void sample_inputs(output bit v[10]);
        v[0] = host5_ok; v[1] = host3_ok; v[2] = card5_ok; v[3] = card3_ok;
        v[4] = brd_sel_a_n; v[5] = brd_sel_b_n; v[6] = pwr_en; v[7] = strap_3v3;
        v[8] = host_rst_n; v[9] = brk_trip;
    endfunction

    always @(posedge clk) begin
        bit now[10];
        bit host_ok, allowed, cards, accepted;
        int nxt;
        if (rst) begin
            d1 = '{0,0,0,0,1,1,0,0,1,0};
            d2 = d1;
            m_fault = 0; m_low = 0; m_good = 0; m_mode = 0;
        end else begin
            host_ok  = d2[7] ? d2[1] : d2[0];
            allowed  = host_ok && !d2[4] && !d2[5] && d2[6] && !m_fault;
            cards    = d2[2] && d2[3];
            accepted = (m_low >= GLT);
            if (!allowed) nxt = 0;
            else if (!cards) nxt = 1;
            else if (accepted || m_good < RSTC) nxt = 2;
            else nxt = 3;
            if (!d2[6]) m_fault = 0;
            else if (d2[9] && m_mode != 0) m_fault = 1;
            m_good = (!(allowed && cards) || accepted) ? 0 : ((m_good < RSTC) ? m_good + 1 : m_good);
            m_low  = d2[8] ? 0 : ((m_low < GLT) ? m_low + 1 : m_low);
            m_mode = nxt;
            sample_inputs(now);
            d2 = d1;
            d1 = now;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            expect_bit("R2 gate3_en vs model", gate3_en, m_mode != 0);
            expect_bit("R2 gate5_en vs model", gate5_en, m_mode != 0);
            expect_bit("R2 drv_en_n vs model", drv_en_n, m_mode == 0);
            expect_bit("R5 healthy_n vs model", healthy_n, !(m_mode >= 2));
            expect_bit("R6 sig_valid_n vs model", sig_valid_n, m_mode != 3);
            expect_bit("R6 lrst_n vs model", lrst_n, m_mode == 3);
            expect_bit("R7 lrst complement", lrst, ~lrst_n);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic all_good();
        host5_ok = 1; host3_ok = 1; card5_ok = 1; card3_ok = 1;
        brd_sel_a_n = 0; brd_sel_b_n = 0; pwr_en = 1; host_rst_n = 1; brk_trip = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cyc(4);
        expect_bit("R1 reset gate3_en", gate3_en, 1'b0);
        expect_bit("R1 reset lrst_n", lrst_n, 1'b0);
        expect_bit("R1 reset healthy_n", healthy_n, 1'b1);
        expect_bit("R1 reset sig_valid_n", sig_valid_n, 1'b1);
        rst = 0;
        cyc(5);
        expect_bit("R1 idle after reset gates", gate5_en, 1'b0);

        // bring up with 5 V host monitor
        all_good();
        cyc(3);
        expect_bit("R2 gates on after three edges", gate3_en, 1'b1);
        expect_bit("R6 still in reset early", lrst_n, 1'b0);
        cyc(30);
        expect_bit("R5 healthy", healthy_n, 1'b0);
        expect_bit("R6 signal valid", sig_valid_n, 1'b0);

        // R8: short host reset rejected
        host_rst_n = 0; cyc(1); host_rst_n = 1;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            expect_bit("R8 glitch ignored", lrst_n, 1'b1);
        end

        // R9: long host reset, stretched
        host_rst_n = 0;
        cyc(25);
        expect_bit("R9 reset during host reset", lrst_n, 1'b0);
        host_rst_n = 1;
        cyc(12);
        expect_bit("R9 reset held after release", lrst, 1'b1);
        cyc(20);
        expect_bit("R9 reset released after hold", lrst_n, 1'b1);

        // R4: card supply sag keeps gates on
        card3_ok = 0;
        cyc(5);
        expect_bit("R4 gates stay on", gate3_en, 1'b1);
        expect_bit("R4 health lost", healthy_n, 1'b1);
        expect_bit("R4 reset asserted", lrst_n, 1'b0);
        card3_ok = 1;
        cyc(30);

        // R3: strap selects 3.3 V monitor
        strap_3v3 = 1; host5_ok = 0;
        cyc(10);
        expect_bit("R3 unselected 5 V monitor ignored", sig_valid_n, 1'b0);
        host3_ok = 0;
        cyc(5);
        expect_bit("R3 selected 3.3 V monitor off", gate3_en, 1'b0);
        host5_ok = 1;
        cyc(10);
        expect_bit("R3 5 V monitor ignored while off", gate5_en, 1'b0);
        host3_ok = 1;
        cyc(30);
        strap_3v3 = 0;
        cyc(5);
        expect_bit("R3 back on 5 V monitor", sig_valid_n, 1'b0);

        // R11: board select released
        brd_sel_b_n = 1;
        cyc(4);
        expect_bit("R11 select released gates off", gate3_en, 1'b0);
        expect_bit("R11 select released reset", lrst, 1'b1);
        brd_sel_b_n = 0;
        cyc(30);

        // R10: breaker trip latches
        brk_trip = 1; cyc(3); brk_trip = 0;
        cyc(3);
        expect_bit("R10 trip gates off", gate5_en, 1'b0);
        cyc(30);
        expect_bit("R10 fault still latched", gate3_en, 1'b0);
        pwr_en = 0; cyc(5); pwr_en = 1;
        cyc(30);
        expect_bit("R10 cleared by power-enable cycle", sig_valid_n, 1'b0);

        // R11: power enable low
        pwr_en = 0;
        cyc(4);
        expect_bit("R11 pwr_en low gates off", gate3_en, 1'b0);
        expect_bit("R11 pwr_en low health", healthy_n, 1'b1);
        cyc(5);
        finish_run();
    end
endmodule